// File: doc/BRIEF.md
# Byte-Wide Self-Synchronous Payload Scrambler with Loopback Descrambler

This block scrambles the payload byte stream of a packet-over-SONET transmit path after framing, frame check generation and byte stuffing have all been done upstream. Every byte presented with its valid strobe is scrambled, and that includes flag and escape characters. The scrambler is multiplicative and self-synchronising with generator x^43 + 1. Each transmitted bit is the incoming bit XORed with the transmitted bit from 43 bit-times earlier. Eight bits are processed per valid clock, most significant bit first.

An enable input turns scrambling off. While it is off, bytes pass through unchanged.

A matching descrambler sits on a separate port group so that a loopback path can be checked. It XORs each received bit with the received bit from 43 bit-times earlier. Because of that, it recovers the original data once 43 bits have entered, with no seed and no alignment. A two-state lock machine marks the first output byte whose bits all rest on received history:

- **FILL**: the state after reset, while fewer than six bytes have been accepted.
- **LOCKED**: entered on the transition **FILL→LOCKED**, taken as the sixth accepted byte enters. The machine stays in LOCKED until reset (**LOCKED→LOCKED**).

Top module: `pos_ssc_scrambler`

## Requirements
- R1: While rst_n is low and on the first cycle after its release, out_valid, rx_out_valid and rx_locked are 0, and out_data and rx_out_data are 0x00. Both history registers start at all zeros.
- R2: With scr_en=1, bit i of each accepted byte is handled in order from bit 7 down to bit 0. The scrambled bit is the input bit XOR the scrambled bit produced 43 bit-times earlier on accepted bytes, with zeros before the first 43 bits.
- R3: out_valid equals in_valid of the previous cycle. The byte accepted in cycle n appears on out_data in cycle n+1.
- R4: Cycles with in_valid=0 leave the scrambler history unchanged and hold out_data at its previous value. The same holds on the receive side for rx_valid=0.
- R5: With scr_en=0, an accepted byte appears unchanged on out_data one cycle later. The history does not advance, so the next enabled byte continues as if the bypassed byte had not been sent.
- R6: With dscr_en=1, each descrambled bit is the received bit XOR the received bit 43 bit-times earlier, most significant bit first, with one cycle latency. Fed with out_data/out_valid after a common reset, it returns the original plain bytes.
- R7: With dscr_en=0, an accepted receive byte appears unchanged on rx_out_data one cycle later. The receive history and the lock count do not change.
- R8: rx_locked is 0 on the outputs of the first six bytes accepted with dscr_en=1 and 1 from the seventh onward until reset. From the seventh byte on, a stream scrambled with an arbitrary unknown starting history is recovered exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scr_en | input | 1 | 1: scramble, 0: pass through |
| in_valid | input | 1 | Transmit byte strobe |
| in_data | input | W | Transmit byte in |
| out_valid | output | 1 | Scrambled byte strobe |
| out_data | output | W | Scrambled byte out |
| dscr_en | input | 1 | 1: descramble, 0: pass through |
| rx_valid | input | 1 | Receive byte strobe |
| rx_data | input | W | Scrambled receive byte in |
| rx_out_valid | output | 1 | Descrambled byte strobe |
| rx_out_data | output | W | Descrambled byte out |
| rx_locked | output | 1 | Descrambler history fully filled (LOCKED) |

## Verification
Both data paths give their result one cycle after the byte is accepted. The lock flag moves together with the seventh accepted byte's output, and in loopback the plain byte returns two cycles after it enters. The bench drives inputs on the falling edge. At the next falling edge it compares every output against the value its bit-queue model predicted for the byte driven one edge earlier, so the single register stage is counted exactly. The mid-stream recovery check collects the descrambler outputs in arrival order and judges them by their byte index, so gaps in the stream cannot shift the point where lock is expected.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
    localparam int unsigned SSC_BYTE_W = 8;
    localparam int unsigned SSC_DELAY  = 43;

    typedef enum logic {
        LK_FILL   = 1'b0,
        LK_LOCKED = 1'b1
    } lk_state_t;
endpackage

// File: rtl/ssc_mult_scr.sv
module ssc_mult_scr #(
    parameter int unsigned W = ssc_pkg::SSC_BYTE_W,
    parameter int unsigned D = ssc_pkg::SSC_DELAY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         vld,
    input  logic [W-1:0] din,
    output logic         dout_vld,
    output logic [W-1:0] dout
);
    logic [D-1:0] hist_q;
    logic [D-1:0] hist_d;
    logic [W-1:0] scr_byte;

    // Unrolled bit-serial recurrence, MSB first; hist[0] is the newest output bit.
    always_comb begin
        logic [D-1:0] h;
        logic         b;
        h = hist_q;
        scr_byte = '0;
        for (int i = W - 1; i >= 0; i--) begin
            b = din[i] ^ h[D-1];
            scr_byte[i] = b;
            h = {h[D-2:0], b};
        end
        hist_d = h;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q   <= '0;
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            dout_vld <= vld;
            if (vld) begin
                dout <= en ? scr_byte : din;
                if (en) begin
                    hist_q <= hist_d;
                end
            end
        end
    end
endmodule

// File: rtl/ssc_mult_dscr.sv
module ssc_mult_dscr #(
    parameter int unsigned W = ssc_pkg::SSC_BYTE_W,
    parameter int unsigned D = ssc_pkg::SSC_DELAY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         vld,
    input  logic [W-1:0] din,
    output logic         dout_vld,
    output logic [W-1:0] dout,
    output logic         locked
);
    import ssc_pkg::*;

    localparam int unsigned LOCK_N = (D + W - 1) / W;
    localparam int unsigned CW     = $clog2(LOCK_N + 1);

    logic [D-1:0]  hist_q;
    logic [D-1:0]  hist_d;
    logic [W-1:0]  plain;
    logic          acc;
    lk_state_t     state_q;
    lk_state_t     state_d;
    logic [CW-1:0] cnt_q;

    assign acc = vld && en;

    // Received bits enter the history; MSB first.
    always_comb begin
        logic [D-1:0] h;
        h = hist_q;
        plain = '0;
        for (int i = W - 1; i >= 0; i--) begin
            plain[i] = din[i] ^ h[D-1];
            h = {h[D-2:0], din[i]};
        end
        hist_d = h;
    end

    // Next-state logic of the lock machine.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_FILL: begin
                if (acc && (cnt_q == CW'(LOCK_N - 1))) begin
                    state_d = LK_LOCKED;
                end
            end
            LK_LOCKED: begin
                state_d = LK_LOCKED;
            end
            default: state_d = LK_FILL;
        endcase
    end

    // State register and fill counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_FILL;
            cnt_q   <= '0;
            hist_q  <= '0;
        end else begin
            state_q <= state_d;
            if (acc) begin
                hist_q <= hist_d;
                if (state_q == LK_FILL) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout     <= '0;
            dout_vld <= 1'b0;
            locked   <= 1'b0;
        end else begin
            dout_vld <= vld;
            if (vld) begin
                dout <= en ? plain : din;
            end
            if (acc) begin
                locked <= (state_q == LK_LOCKED);
            end
        end
    end
endmodule

// File: rtl/pos_ssc_scrambler.sv
module pos_ssc_scrambler #(
    parameter int unsigned W = ssc_pkg::SSC_BYTE_W,
    parameter int unsigned D = ssc_pkg::SSC_DELAY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scr_en,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         dscr_en,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_data,
    output logic         rx_out_valid,
    output logic [W-1:0] rx_out_data,
    output logic         rx_locked
);
    ssc_mult_scr #(.W(W), .D(D)) u_scr (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (scr_en),
        .vld      (in_valid),
        .din      (in_data),
        .dout_vld (out_valid),
        .dout     (out_data)
    );

    ssc_mult_dscr #(.W(W), .D(D)) u_dscr (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (dscr_en),
        .vld      (rx_valid),
        .din      (rx_data),
        .dout_vld (rx_out_valid),
        .dout     (rx_out_data),
        .locked   (rx_locked)
    );
endmodule

// File: rtl/pos_ssc_scrambler_chk.sv
module pos_ssc_scrambler_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         scr_en,
    input logic         in_valid,
    input logic [W-1:0] in_data,
    input logic         out_valid,
    input logic [W-1:0] out_data,
    input logic         dscr_en,
    input logic         rx_valid,
    input logic [W-1:0] rx_data,
    input logic         rx_out_valid,
    input logic [W-1:0] rx_out_data,
    input logic         rx_locked
);
    // R3
    tx_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R4
    tx_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));

    // R5
    tx_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !scr_en) |=> (out_data == $past(in_data)));

    // R6
    rx_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rx_out_valid);

    // R4
    rx_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> (!rx_out_valid && $stable(rx_out_data) && $stable(rx_locked)));

    // R7
    rx_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !dscr_en) |=> (rx_out_data == $past(rx_data) && $stable(rx_locked)));

    // R8
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_locked |=> rx_locked);
endmodule

bind pos_ssc_scrambler pos_ssc_scrambler_chk #(.W(W)) u_chk (.*);

// File: tb/pos_ssc_scrambler_bench.sv
module pos_ssc_scrambler_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scr_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       dscr_en = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_out_valid;
    logic [7:0] rx_out_data;
    logic       rx_locked;

    always #2 clk = ~clk;

    pos_ssc_scrambler u_pos_ssc_scrambler (.*);

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    bit sq[$];
    bit rq[$];
    bit hq[$];
    logic [7:0] lb_q[$];
    logic [7:0] got_d[$];
    logic       got_l[$];

    logic       e_ov, e_rov, e_lock;
    logic [7:0] e_od, e_rod;
    int         rcnt;
    string      tx_tag = "R2";
    string      rx_tag = "R6";
    bit         loop_mode = 1'b0;
    bit         cap_on = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mdl_scr(input logic [7:0] d);
        logic [7:0] r;
        bit b;
        bit h;
        r = '0;
        for (int i = 7; i >= 0; i--) begin
            h = (sq.size() >= 43) ? sq[sq.size() - 43] : 1'b0;
            b = d[i] ^ h;
            r[i] = b;
            sq.push_back(b);
            if (sq.size() > 43) void'(sq.pop_front());
        end
        return r;
    endfunction

    function automatic logic [7:0] mdl_far(input logic [7:0] d);
        logic [7:0] r;
        bit b;
        r = '0;
        for (int i = 7; i >= 0; i--) begin
            b = d[i] ^ hq[0];
            r[i] = b;
            hq.push_back(b);
            void'(hq.pop_front());
        end
        return r;
    endfunction

    function automatic logic [7:0] mdl_dscr(input logic [7:0] d);
        logic [7:0] r;
        bit h;
        r = '0;
        for (int i = 7; i >= 0; i--) begin
            h = (rq.size() >= 43) ? rq[rq.size() - 43] : 1'b0;
            r[i] = d[i] ^ h;
            rq.push_back(d[i]);
            if (rq.size() > 43) void'(rq.pop_front());
        end
        return r;
    endfunction

    task automatic step(input bit tv, input logic [7:0] td, input bit ten,
                        input bit rv, input logic [7:0] rd, input bit ren);
        bit         v;
        logic [7:0] d;
        @(negedge clk);
        chk("R3", "out_valid", 32'(out_valid), 32'(e_ov));
        chk(tx_tag, "out_data", 32'(out_data), 32'(e_od));
        chk("R6", "rx_out_valid", 32'(rx_out_valid), 32'(e_rov));
        chk(rx_tag, "rx_out_data", 32'(rx_out_data), 32'(e_rod));
        chk("R8", "rx_locked", 32'(rx_locked), 32'(e_lock));
        if (loop_mode && rx_out_valid) begin
            if (lb_q.size() > 0) chk("R6", "loopback plain", 32'(rx_out_data), 32'(lb_q.pop_front()));
        end
        if (cap_on && rx_out_valid) begin
            got_d.push_back(rx_out_data);
            got_l.push_back(rx_locked);
        end
        v = rv;
        d = rd;
        if (loop_mode) begin
            v = out_valid;
            d = out_data;
        end
        in_valid = tv; in_data = td; scr_en = ten;
        rx_valid = v;  rx_data = d;  dscr_en = ren;
        e_ov = tv;
        if (tv) begin
            e_od = ten ? mdl_scr(td) : td;
            if (loop_mode && ten) lb_q.push_back(td);
        end
        e_rov = v;
        if (v) begin
            e_rod = ren ? mdl_dscr(d) : d;
            if (ren) begin
                e_lock = (rcnt >= 6);
                rcnt++;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 0; rx_valid = 0; in_data = 0; rx_data = 0;
        sq.delete(); rq.delete(); lb_q.delete();
        e_ov = 0; e_rov = 0; e_lock = 0; e_od = 0; e_rod = 0; rcnt = 0;
        repeat (3) @(negedge clk);
        // R1: values held during reset
        chk("R1", "out_valid in reset", 32'(out_valid), 0);
        chk("R1", "rx_locked in reset", 32'(rx_locked), 0);
        chk("R1", "out_data in reset", 32'(out_data), 0);
        chk("R1", "rx_out_data in reset", 32'(rx_out_data), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [7:0] plain_b[$];
        logic [7:0] pb;
        do_reset();

        // R2 / R6: continuous loopback with plain scrambling and recovery
        loop_mode = 1;
        tx_tag = "R2"; rx_tag = "R6";
        for (int k = 0; k < 40; k++) step(1, 8'(k * 37 + 5), 1, 0, 0, 1);
        // R4: gaps in the stream
        for (int k = 0; k < 30; k++) step(k % 3 == 0, 8'($urandom), 1, 0, 0, 1);
        step(1, 8'h7E, 1, 0, 0, 1);
        step(1, 8'h7D, 1, 0, 0, 1);
        for (int k = 0; k < 4; k++) step(0, 0, 1, 0, 0, 1);
        loop_mode = 0;
        chk("R8", "locked after loopback", 32'(rx_locked), 1);

        // R5: transmit bypass interleaved; R7: receive bypass interleaved
        tx_tag = "R5"; rx_tag = "R7";
        for (int k = 0; k < 40; k++)
            step(1, 8'($urandom), (k % 4) != 1, 1, 8'($urandom), (k % 5) != 2);
        step(1, 8'hFF, 0, 1, 8'h00, 0);
        step(1, 8'h00, 1, 1, 8'hFF, 1);
        step(0, 0, 1, 0, 0, 1);

        // R8: mid-stream start against an unknown starting history
        do_reset();
        tx_tag = "R2"; rx_tag = "R8";
        hq.delete();
        for (int i = 0; i < 43; i++) hq.push_back(bit'($urandom));
        got_d.delete(); got_l.delete();
        cap_on = 1;
        for (int k = 0; k < 14; k++) begin
            pb = 8'($urandom);
            plain_b.push_back(pb);
            step(0, 0, 1, 1, mdl_far(pb), 1);
            if (k == 3) step(0, 0, 1, 0, 0, 1);
        end
        step(0, 0, 1, 0, 0, 1);
        step(0, 0, 1, 0, 0, 1);
        cap_on = 0;
        chk("R8", "captured count", 32'(got_d.size()), 14);
        for (int k = 0; k < 14 && k < got_d.size(); k++) begin
            chk("R8", $sformatf("lock flag byte %0d", k), 32'(got_l[k]), 32'(k >= 6));
            if (k >= 6) chk("R8", $sformatf("recovered byte %0d", k), 32'(got_d[k]), 32'(plain_b[k]));
        end

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule